// File: doc/BRIEF.md
# DC-DC Converter PWM Driver

This block drives two external switching converters with fixed-frequency pulse trains. Each channel counts sixteen ticks of a base-rate clock enable to form one period, and its drive output is active for the first r ticks of the period. The value r is a 4-bit ratio field taken from a shared configuration word. With a 1.536 MHz tick rate this gives a 96 kHz switching frequency. Setting a ratio to zero turns the channel off at once. It also masks the tick enable that feeds that channel's counter, so the counter stays frozen until the channel is turned on again.

Each channel has a feedback input from an external comparator that watches the converter output. The feedback passes through a two-flop synchronizer and is sampled only when a period starts. A low feedback sample keeps the drive inactive for that whole period, so no pulse is ever cut short. The active sense of each drive comes from the level on its drive pin while reset is asserted. A pin pulled high during reset selects an active-low drive, and a pin held low selects an active-high drive.

Each channel is a four-state machine. OFF holds while the ratio is zero. The first gated tick moves it to MARK when the synchronized feedback is high, or to HOLD when it is low. MARK moves to SPACE on the tick at which the count reaches the latched duty. MARK, SPACE and HOLD restart the period on the tick that follows count 15. A zero ratio forces OFF from any state.

Top module: `dcdc_pwm_drv`

## Requirements
- R1: While reset is low and on the cycle after it rises, each drive output equals its inactive level, and both ratio fields read as zero, so both channels are off.
- R2: Channel n takes its ratio from cfg_wdata[4n+3:4n] on a write. A period is 16 tick_en pulses long. When the feedback sampled at the period start is high, the drive is active for the first r pulses of the period.
- R3: A zero ratio forces the channel OFF on the clock edge after the ratio register updates. The drive then sits at its inactive level.
- R4: fb_in is delayed by two clock flops and sampled only at the start of a period. A low sample keeps the drive inactive for the whole period.
- R5: A drive pin sampled high during reset gives an active-low drive (active means 0). A pin sampled low gives an active-high drive. The sampled sense holds until the next reset.
- R6: With r = 15, each period has exactly one inactive tick, and it is the last tick.
- R7: While tick_en is low, no channel state advances. While a channel's ratio is zero, its counter sees no ticks. After re-enabling, the first tick starts a fresh period.
- R8: A change between two nonzero ratios takes effect at the next period start, never in the middle of a period.
- R9: The two channels are independent in phase, ratio, feedback and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; drive-pin sense captured while low |
| tick_en | input | 1 | Base-rate tick enable (one clock wide) |
| cfg_we | input | 1 | Write strobe for the ratio word |
| cfg_wdata | input | 8 | Ratio word, 4 bits per channel, channel 0 in the low nibble |
| fb_in | input | 2 | Asynchronous comparator feedback, one bit per channel |
| pin_sample | input | 2 | Drive-pin level seen by the reset-time sampler |
| drv_out | output | 2 | Drive outputs, one per channel |

## Verification
The bench builds the block with its default of two channels and 4-bit ratios, and it issues a tick on every third clock. With these values every counter wraps in 48 clocks, so several hundred cycles cover many periods at ratios 1, 5, 9 and 15. Two resets with opposite pin samples exercise both polarities on both channels. The bench toggles feedback in the middle of a period and writes ratios part-way through periods, which reaches the boundary-only sampling rules.

// File: rtl/dcdc_pwm_pkg.sv
package dcdc_pwm_pkg;

    // Per-channel controller states
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,  // ratio zero, counter frozen
        CH_HOLD  = 2'd1,  // period running with feedback low: inactive
        CH_MARK  = 2'd2,  // active part of the period
        CH_SPACE = 2'd3   // inactive tail of the period
    } ch_state_e;

endpackage

// File: rtl/dcdc_fb_sync.sv
module dcdc_fb_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dcdc_pwm_cfg.sv
module dcdc_pwm_cfg #(
    parameter int NCH     = 2,
    parameter int RATIO_W = 4,
    localparam int WORD_W = NCH * RATIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [NCH-1:0]    pin_i,
    output logic [WORD_W-1:0] ratio_o,
    output logic [NCH-1:0]    pol_o
);

    logic [WORD_W-1:0] ratio_q;
    logic [NCH-1:0]    pol_q;

    // Ratio word: cleared by reset, so every channel starts off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q <= '0;
        end else if (we_i) begin
            ratio_q <= wdata_i;
        end
    end

    // Drive sense follows the pin level on every clock while reset is low
    // and freezes when reset rises. A high pin means an active-low drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= pin_i;
        end
    end

    assign ratio_o = ratio_q;
    assign pol_o   = pol_q;

    // R5: the sense is fixed outside reset
    p_pol_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(pol_q));

endmodule

// File: rtl/dcdc_pwm_chan.sv
module dcdc_pwm_chan
    import dcdc_pwm_pkg::*;
#(
    parameter int RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               fb_i,
    input  logic               pol_i,
    output logic               drv_o
);

    localparam logic [RATIO_W-1:0] ONE  = RATIO_W'(1);
    localparam logic [RATIO_W-1:0] LAST = '1;

    ch_state_e          state_q, state_n;
    logic [RATIO_W-1:0] cnt_q, cnt_n;
    logic [RATIO_W-1:0] duty_q, duty_n;
    logic               enabled;
    logic               gtick;
    logic               restart;

    // A zero ratio masks the tick that feeds the counter
    assign enabled = (ratio_i != '0);
    assign gtick   = tick_i && enabled;
    assign restart = gtick && ((state_q == CH_OFF) || (cnt_q == LAST));

    // Next-state and counter logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        duty_n  = duty_q;
        if (restart) begin
            state_n = fb_i ? CH_MARK : CH_HOLD;
            cnt_n   = '0;
            duty_n  = ratio_i;
        end else if (gtick) begin
            cnt_n = cnt_q + ONE;
            unique case (state_q)
                CH_MARK: begin
                    if ((cnt_q + ONE) == duty_q) begin
                        state_n = CH_SPACE;
                    end
                end
                CH_SPACE: state_n = CH_SPACE;
                CH_HOLD:  state_n = CH_HOLD;
                CH_OFF:   state_n = CH_OFF;
                default:  state_n = CH_OFF;
            endcase
        end
        if (!enabled) begin
            state_n = CH_OFF;
            cnt_n   = '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
            cnt_q   <= '0;
            duty_q  <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            duty_q  <= duty_n;
        end
    end

    // Output: only MARK drives the active level
    always_comb begin
        drv_o = pol_i;
        unique case (state_q)
            CH_MARK:  drv_o = ~pol_i;
            CH_OFF,
            CH_HOLD,
            CH_SPACE: drv_o = pol_i;
            default:  drv_o = pol_i;
        endcase
    end

    // R3: zero ratio turns the channel off
    p_zero_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_i == '0) |=> (state_q == CH_OFF));
    // R2: the mark never outlasts the latched duty
    p_mark_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_MARK) |-> (cnt_q < duty_q));
    // R6: the last tick of a period is never in the mark
    p_last_tick_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_MARK) |-> (cnt_q != LAST));
    // R4: low feedback at a period start holds the whole period inactive
    p_fb_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !fb_i) |=> (state_q == CH_HOLD));
    // R7: no tick, no counter movement
    p_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && enabled) |=> $stable(cnt_q));
    // R8: the duty only changes at a period start
    p_duty_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart) |=> $stable(duty_q));

endmodule

// File: rtl/dcdc_pwm_drv.sv
module dcdc_pwm_drv #(
    parameter int NCH     = 2,
    parameter int RATIO_W = 4,
    parameter int SYNC_N  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_en,
    input  logic                     cfg_we,
    input  logic [NCH*RATIO_W-1:0]   cfg_wdata,
    input  logic [NCH-1:0]           fb_in,
    input  logic [NCH-1:0]           pin_sample,
    output logic [NCH-1:0]           drv_out
);

    localparam int WORD_W = NCH * RATIO_W;

    logic [WORD_W-1:0] ratio_w;
    logic [NCH-1:0]    pol_w;
    logic [NCH-1:0]    fb_sync_w;

    dcdc_pwm_cfg #(
        .NCH     (NCH),
        .RATIO_W (RATIO_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .pin_i   (pin_sample),
        .ratio_o (ratio_w),
        .pol_o   (pol_w)
    );

    dcdc_fb_sync #(
        .W      (NCH),
        .STAGES (SYNC_N)
    ) u_fb_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (fb_in),
        .sync_o  (fb_sync_w)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dcdc_pwm_chan #(
            .RATIO_W (RATIO_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_en),
            .ratio_i (ratio_w[g*RATIO_W +: RATIO_W]),
            .fb_i    (fb_sync_w[g]),
            .pol_i   (pol_w[g]),
            .drv_o   (drv_out[g])
        );
    end

endmodule

// File: tb/dcdc_pwm_drv_tb.sv
`timescale 1ns/1ps
module dcdc_pwm_drv_tb;

    localparam int NCH = 2;
    localparam int RW  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic              cfg_we = 1'b0;
    logic [NCH*RW-1:0] cfg_wdata = '0;
    logic [NCH-1:0]    fb_in = '0;
    logic [NCH-1:0]    pin_sample = 2'b01;
    logic [NCH-1:0]    drv_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    wd    = 0;
    bit    tick_run = 1'b0;
    bit    done = 1'b0;
    int    tdiv = 0;
    string phase = "R1";

    // Reference model state
    logic [NCH-1:0] m_pol;
    logic [NCH-1:0] m_s1, m_s2;
    int             m_ratio [NCH];
    int             m_pos   [NCH];
    int             m_duty  [NCH];
    bit             m_on    [NCH];

    dcdc_pwm_drv u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .fb_in      (fb_in),
        .pin_sample (pin_sample),
        .drv_out    (drv_out)
    );

    always #2 clk = ~clk;

    task automatic check_bit(string req, int ch, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s ch%0d t=%0t actual=%b expected=%b", req, ch, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Behavioural model: period position per channel, -1 when off
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pol = pin_sample;
            m_s1  = '0;
            m_s2  = '0;
            for (int c = 0; c < NCH; c++) begin
                m_ratio[c] = 0;
                m_pos[c]   = -1;
                m_duty[c]  = 0;
                m_on[c]    = 1'b0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (m_ratio[c] == 0) begin
                    m_pos[c] = -1;
                end else if (tick_en) begin
                    if (m_pos[c] < 0 || m_pos[c] == 15) begin
                        m_pos[c]  = 0;
                        m_duty[c] = m_ratio[c];
                        m_on[c]   = m_s2[c];
                    end else begin
                        m_pos[c] = m_pos[c] + 1;
                    end
                end
            end
            m_s2 = m_s1;
            m_s1 = fb_in;
            if (cfg_we) begin
                for (int c = 0; c < NCH; c++) begin
                    m_ratio[c] = int'((cfg_wdata >> (RW*c)) & 8'h0F);
                end
            end
        end
    end

    // Compare every clock, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < NCH; c++) begin
                bit act;
                act = (m_pos[c] >= 0) && m_on[c] && (m_pos[c] < m_duty[c]);
                check_bit(phase, c, drv_out[c], act ? ~m_pol[c] : m_pol[c]);
            end
        end
    end

    // Tick generator: one pulse every third clock
    always @(negedge clk) begin
        if (!tick_run) begin
            tick_en <= 1'b0;
            tdiv = 0;
        end else begin
            tdiv = (tdiv == 2) ? 0 : tdiv + 1;
            tick_en <= (tdiv == 0);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    task automatic wr(logic [NCH*RW-1:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1 / R5: first reset, ch0 pin high (active low), ch1 pin low
        pin_sample = 2'b01;
        run(5);
        check_bit("R1", 0, drv_out[0], 1'b1);
        check_bit("R1", 1, drv_out[1], 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1", 0, drv_out[0], 1'b1);
        check_bit("R1", 1, drv_out[1], 1'b0);
        pin_sample = 2'b10;  // R5: no effect outside reset
        tick_run = 1'b1;
        fb_in = 2'b11;
        run(20);
        check_bit("R1", 0, drv_out[0], 1'b1);
        check_bit("R5", 1, drv_out[1], 1'b0);

        // R2 / R9: different ratios on each channel
        phase = "R2";
        wr(8'h35);
        run(200);
        wr(8'h17);
        run(150);

        // R8: nonzero changes land part-way through a period
        phase = "R8";
        run(17);
        wr(8'h59);
        run(40);
        wr(8'hC2);
        run(120);

        // R4: feedback drops and returns mid-period
        phase = "R4";
        run(7);
        fb_in = 2'b10;
        run(100);
        fb_in = 2'b01;
        run(29);
        fb_in = 2'b11;
        run(120);

        // R6: maximum ratio
        phase = "R6";
        wr(8'hFF);
        run(150);

        // R3: disable channel 1 only
        phase = "R3";
        wr(8'h0F);
        run(4);
        check_bit("R3", 1, drv_out[1], 1'b0);
        run(100);
        check_bit("R3", 1, drv_out[1], 1'b0);

        // R7: stop ticks, then re-enable after a disabled gap
        phase = "R7";
        tick_run = 1'b0;
        run(60);
        tick_run = 1'b1;
        run(25);
        wr(8'h00);
        run(30);
        wr(8'h46);
        run(150);

        // R5: second reset with opposite pin levels
        phase = "R5";
        @(negedge clk);
        rst_n = 1'b0;
        tick_run = 1'b0;
        pin_sample = 2'b10;
        run(4);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R5", 0, drv_out[0], 1'b0);
        check_bit("R5", 1, drv_out[1], 1'b1);
        tick_run = 1'b1;
        phase = "R9";
        wr(8'hC7);
        run(200);
        fb_in = 2'b01;
        run(150);

        finish_run();
    end

endmodule